// File: doc/BRIEF.md
# UART Channel Modem Control, Ring Detect and Loop-Back

This block sits beside the shift registers of a single UART channel. It owns three things at the pin edge. The first is the serial output pin. The second is the active-low request-to-send pin. The third is the active-low ring-indicator input. A small modem control register, written through a plain write strobe, selects the request-to-send level, the interrupt gate and an internal loop-back mode. In loop-back mode both serial pins are cut off. The transmit stream goes straight to the receiver input, and the serial output pin idles high.

The ring-indicator input first passes through a synchronizer. When the ring ends (the input returns from low to high), a sticky modem-status flag is set. A read of the modem status clears it. The flag drives the interrupt output. A board strap selects how. With the strap high, the flag reaches the interrupt pin at all times. With the strap low, control bit 3 must also be set.

Top module: `uart_modem_ctl`

## Requirements
- R1: The RTS pin `rts_n` is the inverse of control bit 1. Writing 1 to bit 1 drives the pin to 0 in the cycle after the write. After reset the pin is 1.
- R2: While reset is asserted, and in the first cycle after it, `tx_pin` and `rx_ser_out` are 1 and the control register reads 0.
- R3: Loop-back is off when control bit 4 is 0. With loop-back off and `tx_active` high, `tx_pin` equals `tx_ser_in` one cycle later. `rx_ser_out` equals `rx_pin` one cycle later.
- R4: With `tx_active` low, `tx_pin` is 1 one cycle later, whatever `tx_ser_in` carries.
- R5: With control bit 4 set (loop-back), `tx_pin` is held at 1. `rx_pin` has no effect. One cycle later `rx_ser_out` equals `tx_ser_in` while `tx_active` is high, and equals 1 while it is low.
- R6: A transition of `ri_n` from 0 to 1 sets `ri_flag` within SYNC_STAGES+2 cycles. A transition from 1 to 0 does not set it.
- R7: `ri_present` is 1 while the synchronized `ri_n` is 0, which means a ring is present. It follows the pin with a delay of SYNC_STAGES cycles.
- R8: A pulse on `msr_rd` clears `ri_flag` on the next edge. If a new ring-end edge is detected in the same cycle, the flag stays set.
- R9: With `int_sel` high, `irq` equals `ri_flag` regardless of control bit 3.
- R10: With `int_sel` low, `irq` is 1 only when `ri_flag` and control bit 3 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Modem control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit1 RTS, bit3 IRQ gate, bit4 loop-back) |
| msr_rd | input | 1 | Modem status read pulse, clears the ring flag |
| tx_ser_in | input | 1 | Serial data from the transmit shifter |
| tx_active | input | 1 | Transmitter enabled and sending |
| rx_pin | input | 1 | Serial receive pin |
| ri_n | input | 1 | Ring indicator pin, active low |
| int_sel | input | 1 | Interrupt mode strap: 1 always enabled, 0 gated by bit 3 |
| tx_pin | output | 1 | Serial transmit pin |
| rts_n | output | 1 | Request-to-send pin, active low |
| rx_ser_out | output | 1 | Serial data to the receive shifter |
| ri_present | output | 1 | Synchronized ring-present status |
| ri_flag | output | 1 | Sticky ring-end status flag |
| irq | output | 1 | Modem-status interrupt output |
| mctl_q | output | 8 | Current control register value |

## Verification
The serial path is first driven with alternating and long-run bit patterns in normal mode. This shows that the output really follows the transmit data and is not stuck or inverted. The same patterns are then repeated in loop-back mode while `rx_pin` toggles against them. This separates a correct internal route from a leak of the receive pin, and it shows that the transmit pin stays high.

The ring input is driven with a falling edge alone, then a rising edge, then a rise placed in the same cycle as a status read. These cases tell apart edge polarity, the sticky behaviour and the set-over-clear priority. Both strap settings are crossed with both states of the gate bit, which separates the always-enabled interrupt mode from the gated one.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;

  localparam int CTL_W    = 8;
  localparam int RTS_BIT  = 1;
  localparam int IEN_BIT  = 3;
  localparam int LOOP_BIT = 4;

  typedef struct packed {
    logic rts_req;
    logic irq_en;
    logic loop_en;
  } mctl_fields_t;

  function automatic mctl_fields_t decode_mctl(input logic [CTL_W-1:0] v);
    mctl_fields_t f;
    f.rts_req = v[RTS_BIT];
    f.irq_en  = v[IEN_BIT];
    f.loop_en = v[LOOP_BIT];
    return f;
  endfunction

  // Pin level for active-low request-to-send.
  function automatic logic rts_level(input logic req);
    return ~req;
  endfunction

  // Line level offered by the transmit side: idle mark when not sending.
  function automatic logic tx_line(input logic active, input logic data);
    return active ? data : 1'b1;
  endfunction

  // Transmit pin: mark whenever loop-back isolates the pins.
  function automatic logic tx_pin_level(input logic loop, input logic active,
                                        input logic data);
    return loop ? 1'b1 : tx_line(active, data);
  endfunction

  // Receiver input: internal transmit line in loop-back, pin otherwise.
  function automatic logic rx_int_level(input logic loop, input logic active,
                                        input logic data, input logic pin);
    return loop ? tx_line(active, data) : pin;
  endfunction

  function automatic logic irq_level(input logic strap, input logic gate,
                                     input logic flag);
    return flag & (strap | gate);
  endfunction

endpackage

// File: rtl/uart_mctl_reg.sv
module uart_mctl_reg
  import uart_modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] q,
  output mctl_fields_t     fields
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end

  always_comb fields = decode_mctl(q);

endmodule

// File: rtl/uart_ri_detect.sv
module uart_ri_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ri_n,
  input  logic clr,
  output logic ri_sync_n,
  output logic ri_rise,
  output logic flag
);

  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NS-1:0] chain;
  logic          ri_prev;

  generate
    for (genvar i = 0; i < NS; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= ri_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign ri_sync_n = chain[NS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ri_prev <= 1'b1;
    else        ri_prev <= ri_sync_n;
  end

  // End of ring: synchronized line goes from low to high.
  assign ri_rise = ri_sync_n & ~ri_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (ri_rise) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

endmodule

// File: rtl/uart_serial_path.sv
module uart_serial_path
  import uart_modem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic tx_active,
  input  logic tx_ser_in,
  input  logic rx_pin,
  output logic tx_pin,
  output logic rx_ser_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pin     <= 1'b1;
      rx_ser_out <= 1'b1;
    end else begin
      tx_pin     <= tx_pin_level(loop_en, tx_active, tx_ser_in);
      rx_ser_out <= rx_int_level(loop_en, tx_active, tx_ser_in, rx_pin);
    end
  end

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             msr_rd,
  input  logic             tx_ser_in,
  input  logic             tx_active,
  input  logic             rx_pin,
  input  logic             ri_n,
  input  logic             int_sel,
  output logic             tx_pin,
  output logic             rts_n,
  output logic             rx_ser_out,
  output logic             ri_present,
  output logic             ri_flag,
  output logic             irq,
  output logic [CTL_W-1:0] mctl_q
);

  mctl_fields_t mctl;
  logic         ri_sync_n;
  logic         ri_rise;
  logic         loop_en;
  logic         irq_en;

  uart_mctl_reg u_mctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctl_wr),
    .wdata  (ctl_wdata),
    .q      (mctl_q),
    .fields (mctl)
  );

  assign loop_en = mctl.loop_en;
  assign irq_en  = mctl.irq_en;

  uart_ri_detect #(.SYNC_STAGES(SYNC_STAGES)) u_ri (
    .clk       (clk),
    .rst_n     (rst_n),
    .ri_n      (ri_n),
    .clr       (msr_rd),
    .ri_sync_n (ri_sync_n),
    .ri_rise   (ri_rise),
    .flag      (ri_flag)
  );

  uart_serial_path u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_en    (loop_en),
    .tx_active  (tx_active),
    .tx_ser_in  (tx_ser_in),
    .rx_pin     (rx_pin),
    .tx_pin     (tx_pin),
    .rx_ser_out (rx_ser_out)
  );

  assign rts_n      = rts_level(mctl.rts_req);
  assign ri_present = ~ri_sync_n;
  assign irq        = irq_level(int_sel, irq_en, ri_flag);

endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic       msr_rd,
  input logic       tx_ser_in,
  input logic       tx_active,
  input logic       int_sel,
  input logic       tx_pin,
  input logic       rts_n,
  input logic       rx_ser_out,
  input logic       ri_flag,
  input logic       irq,
  input logic       loop_en,
  input logic       irq_en,
  input logic       ri_rise
);

  assert_rts_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> rts_n == !$past(ctl_wdata[1]));

  assert_tx_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !loop_en) |=> tx_pin);

  assert_loop_tx_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> tx_pin);

  assert_loop_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && tx_active) |=> rx_ser_out == $past(tx_ser_in));

  assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ri_rise |=> ri_flag);

  assert_only_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_flag) |-> $past(ri_rise));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !ri_rise) |=> !ri_flag);

  assert_strap_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_sel && ri_flag) |-> irq);

  assert_gate_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_sel && !irq_en) |-> !irq);

  assert_no_spurious_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ri_flag |-> !irq);

endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_wdata  (ctl_wdata),
  .msr_rd     (msr_rd),
  .tx_ser_in  (tx_ser_in),
  .tx_active  (tx_active),
  .int_sel    (int_sel),
  .tx_pin     (tx_pin),
  .rts_n      (rts_n),
  .rx_ser_out (rx_ser_out),
  .ri_flag    (ri_flag),
  .irq        (irq),
  .loop_en    (loop_en),
  .irq_en     (irq_en),
  .ri_rise    (ri_rise)
);

// File: tb/tb_uart_modem_ctl.sv
`timescale 1ns/1ps
module tb_uart_modem_ctl;

  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       msr_rd = 1'b0;
  logic       tx_ser_in = 1'b1;
  logic       tx_active = 1'b0;
  logic       rx_pin = 1'b1;
  logic       ri_n = 1'b1;
  logic       int_sel = 1'b0;
  logic       tx_pin, rts_n, rx_ser_out, ri_present, ri_flag, irq;
  logic [7:0] mctl_q;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  uart_modem_ctl #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .msr_rd(msr_rd), .tx_ser_in(tx_ser_in), .tx_active(tx_active),
    .rx_pin(rx_pin), .ri_n(ri_n), .int_sel(int_sel), .tx_pin(tx_pin),
    .rts_n(rts_n), .rx_ser_out(rx_ser_out), .ri_present(ri_present),
    .ri_flag(ri_flag), .irq(irq), .mctl_q(mctl_q)
  );

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Advance n rising edges, return at the following falling edge.
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_ctl(input logic [7:0] v);
    ctl_wdata = v;
    ctl_wr = 1'b1;
    step(1);
    ctl_wr = 1'b0;
  endtask

  task automatic read_status();
    msr_rd = 1'b1;
    step(1);
    msr_rd = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tx_active = 1'b1;
    tx_ser_in = 1'b0;
    rx_pin = 1'b0;
    step(3);
    check("R2 tx_pin in reset", {7'd0, tx_pin}, 8'd1);
    check("R2 rx_ser_out in reset", {7'd0, rx_ser_out}, 8'd1);
    check("R1 rts_n in reset", {7'd0, rts_n}, 8'd1);
    check("R2 control in reset", mctl_q, 8'h00);
    tx_active = 1'b0;
    tx_ser_in = 1'b1;
    rx_pin = 1'b1;
    rst_n = 1'b1;
    step(1);
    check("R2 tx_pin after reset", {7'd0, tx_pin}, 8'd1);
    check("R6 no flag after reset", {7'd0, ri_flag}, 8'd0);
  endtask

  task automatic t_rts();
    write_ctl(8'h02);
    check("R1 rts_n low after bit1 set", {7'd0, rts_n}, 8'd0);
    write_ctl(8'hFD);
    check("R1 rts_n high after bit1 cleared", {7'd0, rts_n}, 8'd1);
    write_ctl(8'h00);
  endtask

  task automatic t_normal_serial();
    logic [15:0] pat = 16'b1010_0011_1100_0101;
    tx_active = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tx_ser_in = pat[i];
      rx_pin = ~pat[i];
      step(1);
      check("R3 tx_pin follows tx data", {7'd0, tx_pin}, {7'd0, pat[i]});
      check("R3 rx_ser_out follows rx_pin", {7'd0, rx_ser_out}, {7'd0, ~pat[i]});
    end
  endtask

  task automatic t_tx_disabled();
    tx_active = 1'b0;
    tx_ser_in = 1'b0;
    step(1);
    check("R4 tx_pin idle while inactive", {7'd0, tx_pin}, 8'd1);
    step(2);
    check("R4 tx_pin stays idle", {7'd0, tx_pin}, 8'd1);
    tx_ser_in = 1'b1;
  endtask

  task automatic t_loopback();
    logic [11:0] pat = 12'b0110_1001_0010;
    write_ctl(8'h10);
    tx_active = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tx_ser_in = pat[i];
      rx_pin = pat[i];
      rx_pin = ~rx_pin;
      step(1);
      check("R5 tx_pin held high in loop-back", {7'd0, tx_pin}, 8'd1);
      check("R5 rx_ser_out takes tx data", {7'd0, rx_ser_out}, {7'd0, pat[i]});
    end
    tx_active = 1'b0;
    tx_ser_in = 1'b0;
    rx_pin = 1'b0;
    step(1);
    check("R5 loop-back idle line is mark", {7'd0, rx_ser_out}, 8'd1);
    write_ctl(8'h00);
    rx_pin = 1'b1;
    tx_ser_in = 1'b1;
    step(1);
    check("R3 rx pin reconnected after loop-back", {7'd0, rx_ser_out}, 8'd1);
  endtask

  task automatic t_ring_edges();
    read_status();
    ri_n = 1'b0;
    step(SYNC - 1);
    check("R7 ri_present not yet", {7'd0, ri_present}, 8'd0);
    step(1);
    check("R7 ri_present after sync", {7'd0, ri_present}, 8'd1);
    step(3);
    check("R6 falling edge sets no flag", {7'd0, ri_flag}, 8'd0);
    ri_n = 1'b1;
    step(SYNC + 1);
    check("R6 rising edge sets flag", {7'd0, ri_flag}, 8'd1);
    check("R7 ri_present cleared", {7'd0, ri_present}, 8'd0);
    step(4);
    check("R8 flag sticky", {7'd0, ri_flag}, 8'd1);
    read_status();
    check("R8 read clears flag", {7'd0, ri_flag}, 8'd0);
  endtask

  task automatic t_set_beats_read();
    ri_n = 1'b0;
    step(SYNC + 3);
    ri_n = 1'b1;
    step(SYNC);
    msr_rd = 1'b1;
    step(1);
    msr_rd = 1'b0;
    check("R8 set wins over read", {7'd0, ri_flag}, 8'd1);
  endtask

  task automatic t_irq_modes();
    // ri_flag is set on entry
    int_sel = 1'b1;
    write_ctl(8'h00);
    check("R9 strap high, gate 0", {7'd0, irq}, 8'd1);
    write_ctl(8'h08);
    check("R9 strap high, gate 1", {7'd0, irq}, 8'd1);
    int_sel = 1'b0;
    step(1);
    check("R10 strap low, gate 1", {7'd0, irq}, 8'd1);
    write_ctl(8'h00);
    check("R10 strap low, gate 0", {7'd0, irq}, 8'd0);
    write_ctl(8'h08);
    read_status();
    check("R10 no irq without flag", {7'd0, irq}, 8'd0);
    int_sel = 1'b1;
    step(1);
    check("R9 no irq without flag", {7'd0, irq}, 8'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    t_reset();
    t_rts();
    t_normal_serial();
    t_tx_disabled();
    t_loopback();
    t_ring_edges();
    t_set_beats_read();
    t_irq_modes();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule